// File: doc/BRIEF.md
# Bus Master FIFO Status, Flush and Interrupt Controller

This block holds the transmit and receive word queues of a packet-mode serial bus master, together with the control and event logic that software uses to service them. Software reaches it through a small register port: it pushes outgoing 32-bit words, pops incoming words, and programs per-direction trigger levels and flush commands. It also reads the queue occupancy, enables individual events and acknowledges them. The protocol engine is not part of the block. It is represented by a pop strobe on the transmit queue, a push strobe on the receive queue, and single-cycle pulses that report transfer completion, a missing acknowledge and lost arbitration.

Every event lands in a sticky status bit, and software clears it by writing a one to that bit. A per-bit enable register selects which events drive the single level-sensitive interrupt output. Data-request events are recomputed every cycle from the queue occupancy and the programmed trigger levels. A flush empties its queue at once, and its control bit reads back as busy for a fixed number of cycles before it clears itself.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0, the enable register reads 0, the queue status register reads 0x80, and irq_o is low.
- R2: Each queue holds 8 words and returns them in first-in first-out order. The queue status register (address 1) reports free transmit slots in bits 7:4 and stored receive words in bits 3:0.
- R3: A software write to the transmit data address (4) while the transmit queue holds 8 words discards the word, leaves the queue unchanged, and sets event bit 5.
- R4: A software read of the receive data address (5) with the receive queue empty returns 0 and sets event bit 4.
- R5: Writing 1 to control bit 1 empties the transmit queue, and writing 1 to control bit 0 empties the receive queue. In both cases the queue is empty by the next read. The written bit reads 1 for exactly two cycles after the write and then reads 0 with no further write. The other queue is not affected.
- R6: Control bits 7:5 hold the transmit trigger T and bits 4:2 hold the receive trigger L. Event bit 1 is set in every cycle in which the free transmit slots exceed T. Event bit 0 is set in every cycle in which the stored receive words exceed L. With L=0, a single word is enough to raise the request.
- R7: A one-cycle pulse on xfer_done_i, all_done_i, nack_i or arb_lost_i sets event bit 7, 6, 3 or 2 respectively, and the bit stays set.
- R8: Writing the event register (address 3) clears each bit written as 1 and leaves each bit written as 0. Writing 0xFF clears every bit whose set condition is not active. A bit whose set condition is active in the same cycle as its clear stays set.
- R9: A 1 in an enable register bit (address 2) routes that event to irq_o. irq_o is the registered OR of the enabled event bits: it rises one cycle after an enabled bit is set and stays high until those bits are cleared or disabled.
- R10: Registers are decoded on reg_addr_i as 0 control, 1 queue status, 2 enable, 3 events, 4 transmit data (write), 5 receive data (read, pops). The enable register reads back the value written to its low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops at address 5) |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| tx_data_o | output | 32 | Head word of the transmit queue, 0 when empty |
| tx_valid_o | output | 1 | Transmit queue not empty |
| tx_pop_i | input | 1 | Engine takes the transmit head word |
| rx_push_i | input | 1 | Engine stores a received word |
| rx_data_i | input | 32 | Received word |
| xfer_done_i | input | 1 | Packet transfer complete pulse |
| all_done_i | input | 1 | All packets complete pulse |
| nack_i | input | 1 | Missing acknowledge pulse |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted occupancy count shows up in the queue status nibbles on the very next register read. Because the data-request bits are refreshed every cycle, it also shows up in those bits one cycle later. A stuck flush counter keeps the control bit reading 1 past its second cycle and holds the queue empty. A broken event latch or enable path appears on irq_o within two cycles of the triggering pulse, or as irq_o staying high after the acknowledging write. Randomized push and pop traffic against a queue model in the bench compares every popped word and every occupancy reading. The overflow and underflow bits that the model expects are compared at the end.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int NEV      = 8;
  localparam int EV_XFER  = 7;
  localparam int EV_ALL   = 6;
  localparam int EV_TXOVF = 5;
  localparam int EV_RXUDF = 4;
  localparam int EV_NACK  = 3;
  localparam int EV_ARB   = 2;
  localparam int EV_TXREQ = 1;
  localparam int EV_RXREQ = 0;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_FSTAT = 3'd1,
    A_MASK  = 3'd2,
    A_ISTAT = 3'd3,
    A_TXD   = 3'd4,
    A_RXD   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/fic_flush.sv
module fic_flush #(
  parameter int CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic clr_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign clr_o  = start_i | busy_o;

  // R5
  flush_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/fic_fifo.sv
module fic_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push_i & ~full & ~clr_i;
  assign pop_ok  = pop_i & ~empty & ~clr_i;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (clr_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assign rdata_o = empty ? '0 : mem_q[rptr_q];
  assign count_o = count_q;

  // R2
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !clr_i) |=> (count_q == CW'(DEPTH)));
  // R5
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q == '0));
endmodule

// File: rtl/fic_irq.sv
module fic_irq #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, mask_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~w1c_i) | set_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
      irq_q <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  // R8
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(w1c_i & ~set_i)) |=> ((status_q & $past(w1c_i & ~set_i)) == '0));
  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(set_i & mask_q)) && !mask_we_i) |-> ##2 irq_o);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int DW        = 32,
  parameter int DEPTH     = 8,
  parameter int FLUSH_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_pop_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          xfer_done_i,
  input  logic          all_done_i,
  input  logic          nack_i,
  input  logic          arb_lost_i,
  output logic          irq_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = 3;

  logic [TW-1:0]  tx_trig_q, rx_trig_q;
  logic [1:0]     flush_start, flush_busy, flush_clr;
  logic [CW-1:0]  tx_cnt, rx_cnt, tx_free;
  logic [DW-1:0]  rx_head;
  logic           ctrl_wr, sw_tx_push, sw_rx_pop, tx_full, rx_empty;
  logic [NEV-1:0] ev_set, ev_w1c, istat, mask;

  assign ctrl_wr    = reg_wr_i && (reg_addr_i == A_CTRL);
  assign sw_tx_push = reg_wr_i && (reg_addr_i == A_TXD);
  assign sw_rx_pop  = reg_rd_i && (reg_addr_i == A_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_trig_q <= '0;
      rx_trig_q <= '0;
    end else if (ctrl_wr) begin
      tx_trig_q <= reg_wdata_i[7:5];
      rx_trig_q <= reg_wdata_i[4:2];
    end
  end

  // index 0 = receive, 1 = transmit
  assign flush_start = {2{ctrl_wr}} & reg_wdata_i[1:0];

  for (genvar d = 0; d < 2; d++) begin : g_flush
    fic_flush #(.CYC(FLUSH_CYC)) i_flush (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (flush_start[d]),
      .busy_o  (flush_busy[d]),
      .clr_o   (flush_clr[d])
    );
  end

  fic_fifo #(.DW(DW), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (flush_clr[1]),
    .push_i  (sw_tx_push),
    .wdata_i (reg_wdata_i),
    .pop_i   (tx_pop_i),
    .rdata_o (tx_data_o),
    .count_o (tx_cnt)
  );

  fic_fifo #(.DW(DW), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (flush_clr[0]),
    .push_i  (rx_push_i),
    .wdata_i (rx_data_i),
    .pop_i   (sw_rx_pop),
    .rdata_o (rx_head),
    .count_o (rx_cnt)
  );

  assign tx_free    = CW'(DEPTH) - tx_cnt;
  assign tx_full    = (tx_cnt == CW'(DEPTH));
  assign rx_empty   = (rx_cnt == '0);
  assign tx_valid_o = (tx_cnt != '0);

  always_comb begin
    ev_set           = '0;
    ev_set[EV_XFER]  = xfer_done_i;
    ev_set[EV_ALL]   = all_done_i;
    ev_set[EV_TXOVF] = sw_tx_push && tx_full && !flush_clr[1];
    ev_set[EV_RXUDF] = sw_rx_pop && rx_empty;
    ev_set[EV_NACK]  = nack_i;
    ev_set[EV_ARB]   = arb_lost_i;
    ev_set[EV_TXREQ] = tx_free > CW'(tx_trig_q);
    ev_set[EV_RXREQ] = rx_cnt > CW'(rx_trig_q);
  end

  assign ev_w1c = (reg_wr_i && (reg_addr_i == A_ISTAT)) ? reg_wdata_i[NEV-1:0] : '0;

  fic_irq #(.N(NEV)) i_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (ev_set),
    .w1c_i        (ev_w1c),
    .mask_we_i    (reg_wr_i && (reg_addr_i == A_MASK)),
    .mask_wdata_i (reg_wdata_i[NEV-1:0]),
    .status_o     (istat),
    .mask_o       (mask),
    .irq_o        (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o[7:0] = {tx_trig_q, rx_trig_q, flush_busy[1], flush_busy[0]};
      A_FSTAT: reg_rdata_o[7:0] = {4'(tx_free), 4'(rx_cnt)};
      A_MASK:  reg_rdata_o[NEV-1:0] = mask;
      A_ISTAT: reg_rdata_o[NEV-1:0] = istat;
      A_RXD:   reg_rdata_o = rx_head;
      default: reg_rdata_o = '0;
    endcase
  end

  // R4
  rx_udf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rx_pop && rx_empty) |=> istat[EV_RXUDF]);
  // R7
  nack_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i |=> istat[EV_NACK]);
endmodule

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, tx_data_o, rx_data_i = '0;
  logic        tx_valid_o, tx_pop_i = 1'b0, rx_push_i = 1'b0;
  logic        xfer_done_i = 1'b0, all_done_i = 1'b0, nack_i = 1'b0, arb_lost_i = 1'b0;
  logic        irq_o;

  int nchk = 0, nerr = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [31:0] v;

  always #4 clk = ~clk;

  fifo_irq_ctrl i_fifo_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_pop_i(tx_pop_i),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i), .xfer_done_i(xfer_done_i),
    .all_done_i(all_done_i), .nack_i(nack_i), .arb_lost_i(arb_lost_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] fstat_exp(int t, int r);
    return {24'b0, 4'(DEPTH - t), 4'(r)};
  endfunction

  function automatic logic irq_exp(logic [7:0] st, logic [7:0] m);
    return |(st & m);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rx_read(output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = 3'd5; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 1'b0;
  endtask

  task automatic eng_rx_push(logic [31:0] d);
    @(negedge clk);
    rx_push_i = 1'b1; rx_data_i = d;
    @(negedge clk);
    rx_push_i = 1'b0;
  endtask

  task automatic eng_tx_pop(output logic [31:0] d);
    @(negedge clk);
    d = tx_data_o;
    tx_pop_i = 1'b1;
    @(negedge clk);
    tx_pop_i = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] r, st;
    logic ovf_m, udf_m;
    void'($urandom(32'h5eed_1234));
    wait_cyc(3);
    rst_ni = 1'b1;

    // R1 reset state
    peek(3'd0, r); check("R1 ctrl", r, 32'h0);
    peek(3'd1, r); check("R1 fstat", r, 32'h80);
    peek(3'd2, r); check("R1 mask", r, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R10 enable register readback
    reg_write(3'd2, 32'h5A);
    peek(3'd2, r); check("R10 mask readback", r, 32'h5A);
    reg_write(3'd2, 32'h80);

    // R7 / R9 event latch and interrupt
    @(negedge clk); xfer_done_i = 1'b1;
    @(negedge clk); xfer_done_i = 1'b0;
    wait_cyc(1);
    peek(3'd3, r); check("R7 xfer bit", r & 32'hFC, 32'h80);
    check("R9 irq rises", {31'b0, irq_o}, {31'b0, irq_exp(8'h80, 8'h80)});
    @(negedge clk); nack_i = 1'b1; arb_lost_i = 1'b1; all_done_i = 1'b1;
    @(negedge clk); nack_i = 1'b0; arb_lost_i = 1'b0; all_done_i = 1'b0;
    peek(3'd3, r); check("R7 nack/arb/all bits", r & 32'hFC, 32'hCC);

    // R8 clear one bit, others stay
    reg_write(3'd3, 32'h80);
    peek(3'd3, r); check("R8 w1c single", r & 32'hFC, 32'h4C);
    wait_cyc(1);
    check("R9 irq drops after clear", {31'b0, irq_o}, 32'h0);
    reg_write(3'd2, 32'h08);
    wait_cyc(1);
    check("R9 irq via enable change", {31'b0, irq_o}, 32'h1);

    // R8 set wins over clear
    @(negedge clk); nack_i = 1'b1; reg_wr_i = 1'b1; reg_addr_i = 3'd3; reg_wdata_i = 32'h08;
    @(negedge clk); nack_i = 1'b0; reg_wr_i = 1'b0;
    peek(3'd3, r); check("R8 set wins", r & 32'h08, 32'h08);
    reg_write(3'd3, 32'hFF);
    peek(3'd3, r); check("R8 clear all", r & 32'hFC, 32'h0);
    wait_cyc(1);
    check("R9 irq low after clear all", {31'b0, irq_o}, 32'h0);
    reg_write(3'd2, 32'h00);

    // R3 overflow and R2 ordering on transmit
    for (int i = 0; i < DEPTH; i++) reg_write(3'd4, 32'hA000_0000 + i);
    peek(3'd1, r); check("R2 tx full status", r, fstat_exp(8, 0));
    reg_write(3'd4, 32'hDEAD_BEEF);
    peek(3'd3, r); check("R3 overflow bit", r & 32'h20, 32'h20);
    peek(3'd1, r); check("R3 queue unchanged", r, fstat_exp(8, 0));
    for (int i = 0; i < DEPTH; i++) begin
      eng_tx_pop(v);
      check("R2 tx order", v, 32'hA000_0000 + i);
    end
    check("R3 dropped word absent", {31'b0, tx_valid_o}, 32'h0);
    peek(3'd1, r); check("R2 tx empty status", r, fstat_exp(0, 0));

    // R4 underflow
    rx_read(v); check("R4 empty read data", v, 32'h0);
    peek(3'd3, r); check("R4 underflow bit", r & 32'h10, 32'h10);

    // R2 receive ordering
    for (int i = 0; i < 3; i++) eng_rx_push(32'hB000_0000 + i);
    peek(3'd1, r); check("R2 rx count", r, fstat_exp(0, 3));
    for (int i = 0; i < 3; i++) begin
      rx_read(v); check("R2 rx order", v, 32'hB000_0000 + i);
    end

    // R5 flush
    for (int i = 0; i < 3; i++) reg_write(3'd4, i);
    for (int i = 0; i < 2; i++) eng_rx_push(i);
    reg_write(3'd0, 32'h02);
    peek(3'd0, r); check("R5 tx flush busy c1", r, 32'h02);
    peek(3'd1, r); check("R5 tx flushed rx kept", r, fstat_exp(0, 2));
    @(negedge clk); peek(3'd0, r); check("R5 tx flush busy c2", r, 32'h02);
    @(negedge clk); peek(3'd0, r); check("R5 tx flush self clear", r, 32'h00);
    reg_write(3'd0, 32'h01);
    peek(3'd0, r); check("R5 rx flush busy", r, 32'h01);
    peek(3'd1, r); check("R5 rx flushed", r, fstat_exp(0, 0));
    wait_cyc(2);
    peek(3'd0, r); check("R5 rx flush self clear", r, 32'h00);

    // R6 receive trigger L=2
    reg_write(3'd0, 32'h08);
    peek(3'd0, r); check("R6 ctrl readback", r, 32'h08);
    eng_rx_push(32'h1); eng_rx_push(32'h2);
    wait_cyc(2);
    reg_write(3'd3, 32'h01);
    wait_cyc(2);
    peek(3'd3, r); check("R6 rx req below level", r & 32'h01, 32'h0);
    eng_rx_push(32'h3);
    wait_cyc(2);
    peek(3'd3, r); check("R6 rx req above level", r & 32'h01, 32'h01);
    // transmit trigger T=7
    reg_write(3'd0, 32'hE0);
    reg_write(3'd3, 32'h02);
    wait_cyc(2);
    peek(3'd3, r); check("R6 tx req empty queue", r & 32'h02, 32'h02);
    reg_write(3'd4, 32'h77);
    wait_cyc(2);
    reg_write(3'd3, 32'h02);
    wait_cyc(2);
    peek(3'd3, r); check("R6 tx req off at 7 free", r & 32'h02, 32'h0);
    reg_write(3'd0, 32'h03);
    wait_cyc(3);
    peek(3'd1, r); check("R5 both flushed", r, fstat_exp(0, 0));

    // random traffic against queue model
    txq.delete(); rxq.delete();
    reg_write(3'd3, 32'hFF);
    ovf_m = 1'b0; udf_m = 1'b0;
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 3));
      d = $urandom;
      case (op)
        0: begin
          reg_write(3'd4, d);
          if (txq.size() < DEPTH) txq.push_back(d); else ovf_m = 1'b1;
        end
        1: begin
          eng_tx_pop(v);
          if (txq.size() > 0) begin
            check("R2 random tx data", v, txq.pop_front());
          end
        end
        2: begin
          eng_rx_push(d);
          if (rxq.size() < DEPTH) rxq.push_back(d);
        end
        default: begin
          rx_read(v);
          if (rxq.size() > 0) check("R2 random rx data", v, rxq.pop_front());
          else begin
            check("R4 random empty read", v, 32'h0);
            udf_m = 1'b1;
          end
        end
      endcase
      peek(3'd1, r);
      check("R2 random status", r, fstat_exp(txq.size(), rxq.size()));
    end
    peek(3'd3, st);
    check("R3 R4 random ovf/udf bits", st & 32'h30, {26'b0, ovf_m, udf_m, 4'b0});
    check("R9 irq masked off", {31'b0, irq_o}, {31'b0, irq_exp(st[7:0], 8'h00)});

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule